// File: doc/BRIEF.md
# Queue-Channel Mailbox Requester

This engine sits on the virtual-function side of a 256-bit shared mailbox and opens or closes the hardware command channel through it. A single start pulse launches a request. The request is either an *open* request or a *close* request. An open request carries the physical addresses of four queues (event, completion, receive, send), an interrupt vector index and a reset flag. A close request carries only the reset flag. The mailbox storage is outside the block. The engine reaches it through a dword-wide port. A read returns its data on the cycle after the read strobe.

Ownership of the mailbox is shown by bit 31 of dword 7. The engine first polls that dword until the bit reads 0, which means the function owns the mailbox. For an open request it then validates the arguments and writes the packed request. It then polls again until the other side hands the mailbox back, and checks the reply header. Both poll loops are bounded by a poll-count limit, with a programmable idle gap between polls. The result is reported as a done level and a two-bit error code, and both hold until the next accepted start.

Top module: `mbx_setup_engine`

## Requirements
- R1: After reset, busy, done, the mailbox read strobe and the mailbox write strobe are all 0, and err is 0 (none).
- R2: Before writing anything, the engine reads dword 7 until bit 31 is 0. If MAX_POLLS consecutive reads all show bit 31 set, it finishes with err = 1 (timeout) and performs no write. MAX_POLLS-1 busy reads followed by a free read let the request proceed.
- R3: An open request finishes with err = 2 (invalid argument) and no write when any queue address has a nonzero bit in 11:0, or when the vector index has a nonzero bit in 31:16. A close request does not check the addresses or the vector.
- R4: An open request packs its data as follows. Frame number = address >> 12. Bits 47:0 of the four frame numbers fill bytes 0–23 in the order event, completion, receive, send. Frame bits 51:48 of each queue form a 16-bit word at bytes 24–25, with event in nibble 0 through send in nibble 3. The vector's low 16 bits go in bytes 26–27. Dword k holds bytes 4k..4k+3, least significant byte first.
- R5: An open request writes dwords 0 to 7 in consecutive cycles and ascending order. Dword 7 is the header: type in bits 2:0 = 1, version in bits 5:3 = 0, direction in bit 7 = 0, status in bits 15:8 = 0, reset flag in bit 24, and all other bits 0.
- R6: A close request writes only dword 7, with type 2, version 0, direction 0 and the reset flag in bit 24.
- R7: After a poll read that shows bit 31 set, the next read comes exactly WAIT_CYCLES+2 cycles later. A request with no busy polls finishes 4+W cycles after the start edge, where W is the number of dwords written, and each busy poll adds WAIT_CYCLES+2 cycles.
- R8: After the header write, the engine polls dword 7 again with the same limit, and a timeout gives err = 1. When the reset flag was set, a readback of 0xFFFFFFFF ends the request at once with err = 0. Without the reset flag, the same value counts as busy.
- R9: The reply is accepted (err = 0) only if its type equals the request type, its version is not greater than REQ_VER, direction bit 7 is 1, and status bits 15:8 are 0. Any other reply gives err = 3 (protocol error).
- R10: A start while busy is ignored. After a request ends, done and err keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request (sampled when idle) |
| close_req | input | 1 | 0 = open channel, 1 = close channel |
| reset_req | input | 1 | Reset flag carried in the header |
| evq_addr | input | 64 | Event queue physical address |
| cmpq_addr | input | 64 | Completion queue physical address |
| rxq_addr | input | 64 | Receive queue physical address |
| txq_addr | input | 64 | Send queue physical address |
| irq_vec | input | 32 | Interrupt vector index |
| mb_rd | output | 1 | Mailbox read strobe (always dword 7) |
| mb_wr | output | 1 | Mailbox write strobe |
| mb_addr | output | 3 | Mailbox dword index |
| mb_wdata | output | 32 | Mailbox write data |
| mb_rdata | input | 32 | Mailbox read data, valid the cycle after mb_rd |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request finished, held until next start |
| err | output | 2 | 0 none, 1 timeout, 2 invalid argument, 3 protocol |

## Verification
The hardest situations to reach are those that depend on what the far side of the mailbox does over time. These are a busy reply on exactly the last allowed poll, the all-ones readback after the header write (with and without the reset flag), and a start that arrives in the middle of a running request. The bench models the mailbox itself. Before each request it is loaded with the number of busy reads to return before the header write, the number to return after it, and the final reply word. This places every loop boundary and every reply variant at a chosen cycle, and the measured start-to-done latency confirms the number of polls and the idle gap.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int NQ         = 4;
    localparam int DW         = 32;
    localparam int NDW        = 8;
    localparam int FRAME_W    = NDW * DW;
    localparam int ADDR_W     = $clog2(NDW);
    localparam int PAGE_SHIFT = 12;
    localparam int PFN_W      = 52;
    localparam int PFN_LO_W   = 48;
    localparam int PFN_HI_W   = PFN_W - PFN_LO_W;
    localparam logic [ADDR_W-1:0] HDR_IDX = ADDR_W'(NDW - 1);

    localparam logic [2:0] MSG_OPEN  = 3'd1;
    localparam logic [2:0] MSG_CLOSE = 3'd2;

    localparam int OWNER_BIT = 31;
    localparam int DIR_BIT   = 7;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_TIMEOUT = 2'd1,
        ERR_INVAL   = 2'd2,
        ERR_PROTO   = 2'd3
    } mbx_err_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_CHK,
        ST_WAIT,
        ST_WR
    } mbx_state_e;

    typedef struct packed {
        logic       owner;
        logic [5:0] rsv3;
        logic       reset;
        logic [7:0] rsv2;
        logic [7:0] status;
        logic       dir;
        logic       rsv1;
        logic [2:0] ver;
        logic [2:0] mtype;
    } mbx_hdr_t;

    function automatic mbx_hdr_t make_req_hdr(input logic [2:0] mtype, input logic rst_flag);
        mbx_hdr_t h;
        h        = '0;
        h.mtype  = mtype;
        h.ver    = 3'd0;
        h.dir    = 1'b0;
        h.reset  = rst_flag;
        return h;
    endfunction
endpackage

// File: rtl/mbx_poll_timer.sv
module mbx_poll_timer #(
    parameter int MAX_POLLS   = 20000,
    parameter int WAIT_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic miss,
    output logic limit_hit,
    output logic wait_done
);
    localparam int PCW = $clog2(MAX_POLLS + 1);
    localparam int WCW = $clog2(WAIT_CYCLES + 1);

    logic [PCW-1:0] poll_cnt;
    logic [WCW-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            poll_cnt <= '0;
            wait_cnt <= '0;
        end else if (miss) begin
            poll_cnt <= poll_cnt + 1'b1;
            wait_cnt <= WCW'(WAIT_CYCLES - 1);
        end else if (wait_cnt != '0) begin
            wait_cnt <= wait_cnt - 1'b1;
        end
    end

    assign limit_hit = (poll_cnt == PCW'(MAX_POLLS - 1));
    assign wait_done = (wait_cnt == '0);
endmodule

// File: rtl/mbx_frame_packer.sv
module mbx_frame_packer
    import mbx_pkg::*;
(
    input  logic [NQ-1:0][63:0]  q_addr,
    input  logic [31:0]          vec,
    input  logic                 reset_flag,
    input  logic                 close_flag,
    output logic [FRAME_W-1:0]   frame,
    output logic                 args_ok
);
    logic [NQ*PFN_LO_W-1:0] lo_parts;
    logic [NQ*PFN_HI_W-1:0] hi_parts;
    logic [NQ-1:0]          aligned;
    mbx_hdr_t               hdr;

    for (genvar q = 0; q < NQ; q++) begin : g_queue
        logic [PFN_W-1:0] pfn;
        assign pfn = q_addr[q][PAGE_SHIFT +: PFN_W];
        assign lo_parts[q*PFN_LO_W +: PFN_LO_W] = pfn[PFN_LO_W-1:0];
        assign hi_parts[q*PFN_HI_W +: PFN_HI_W] = pfn[PFN_W-1:PFN_LO_W];
        assign aligned[q] = (q_addr[q][PAGE_SHIFT-1:0] == '0);
    end

    assign hdr     = make_req_hdr(close_flag ? MSG_CLOSE : MSG_OPEN, reset_flag);
    assign frame   = {hdr, vec[15:0], hi_parts, lo_parts};
    assign args_ok = (&aligned) && (vec[31:16] == 16'h0);
endmodule

// File: rtl/mbx_resp_check.sv
module mbx_resp_check
    import mbx_pkg::*;
(
    input  logic [DW-1:0] rdata,
    input  logic [2:0]    exp_type,
    input  logic [2:0]    req_ver,
    input  logic          reset_flag,
    output logic          owned_by_peer,
    output logic          reset_seen,
    output logic          reply_ok
);
    assign owned_by_peer = rdata[OWNER_BIT];
    assign reset_seen    = reset_flag && (rdata == {DW{1'b1}});
    assign reply_ok      = (rdata[2:0] == exp_type) &&
                           (rdata[5:3] <= req_ver) &&
                           rdata[DIR_BIT] &&
                           (rdata[15:8] == 8'h00);
endmodule

// File: rtl/mbx_setup_engine.sv
module mbx_setup_engine
    import mbx_pkg::*;
#(
    parameter int         MAX_POLLS   = 20000,
    parameter int         WAIT_CYCLES = 1000,
    parameter logic [2:0] REQ_VER     = 3'd0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        close_req,
    input  logic        reset_req,
    input  logic [63:0] evq_addr,
    input  logic [63:0] cmpq_addr,
    input  logic [63:0] rxq_addr,
    input  logic [63:0] txq_addr,
    input  logic [31:0] irq_vec,
    output logic        mb_rd,
    output logic        mb_wr,
    output logic [2:0]  mb_addr,
    output logic [31:0] mb_wdata,
    input  logic [31:0] mb_rdata,
    output logic        busy,
    output logic        done,
    output logic [1:0]  err
);
    mbx_state_e             state;
    logic                   post_q;
    logic [ADDR_W-1:0]      idx_q;
    logic                   done_q;
    mbx_err_e               err_q;
    logic [NQ-1:0][63:0]    addr_q;
    logic [31:0]            vec_q;
    logic                   close_q;
    logic                   reset_q;

    logic [FRAME_W-1:0]     frame;
    logic                   args_ok;
    logic                   owned;
    logic                   reset_seen;
    logic                   reply_ok;
    logic                   limit_hit;
    logic                   wait_done;
    logic                   tmr_clr;
    logic                   tmr_miss;
    logic                   accept;

    assign accept = (state == ST_IDLE) && start;

    mbx_frame_packer u_pack (
        .q_addr     (addr_q),
        .vec        (vec_q),
        .reset_flag (reset_q),
        .close_flag (close_q),
        .frame      (frame),
        .args_ok    (args_ok)
    );

    mbx_resp_check u_resp (
        .rdata         (mb_rdata),
        .exp_type      (close_q ? MSG_CLOSE : MSG_OPEN),
        .req_ver       (REQ_VER),
        .reset_flag    (reset_q),
        .owned_by_peer (owned),
        .reset_seen    (reset_seen),
        .reply_ok      (reply_ok)
    );

    assign tmr_clr  = accept || (state == ST_WR);
    assign tmr_miss = (state == ST_CHK) && owned && !limit_hit &&
                      !(post_q && reset_seen);

    mbx_poll_timer #(
        .MAX_POLLS   (MAX_POLLS),
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .clr       (tmr_clr),
        .miss      (tmr_miss),
        .limit_hit (limit_hit),
        .wait_done (wait_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            post_q  <= 1'b0;
            idx_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= ERR_NONE;
            addr_q  <= '0;
            vec_q   <= '0;
            close_q <= 1'b0;
            reset_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        addr_q  <= {txq_addr, rxq_addr, cmpq_addr, evq_addr};
                        vec_q   <= irq_vec;
                        close_q <= close_req;
                        reset_q <= reset_req;
                        done_q  <= 1'b0;
                        err_q   <= ERR_NONE;
                        post_q  <= 1'b0;
                        state   <= ST_RD;
                    end
                end
                ST_RD: state <= ST_CHK;
                ST_CHK: begin
                    if (post_q && reset_seen) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                        err_q  <= ERR_NONE;
                    end else if (owned) begin
                        if (limit_hit) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                            err_q  <= ERR_TIMEOUT;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end else if (post_q) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                        err_q  <= reply_ok ? ERR_NONE : ERR_PROTO;
                    end else if (!close_q && !args_ok) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                        err_q  <= ERR_INVAL;
                    end else begin
                        idx_q <= close_q ? HDR_IDX : '0;
                        state <= ST_WR;
                    end
                end
                ST_WAIT: if (wait_done) state <= ST_RD;
                ST_WR: begin
                    if (idx_q == HDR_IDX) begin
                        post_q <= 1'b1;
                        state  <= ST_RD;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mb_rd    = (state == ST_RD);
    assign mb_wr    = (state == ST_WR);
    assign mb_addr  = (state == ST_WR) ? idx_q : HDR_IDX;
    assign mb_wdata = frame[DW*int'(idx_q) +: DW];
    assign busy     = (state != ST_IDLE);
    assign done     = done_q;
    assign err      = err_q;
endmodule

// File: rtl/mbx_setup_checker.sv
module mbx_setup_checker #(
    parameter int WAIT_CYCLES = 1000
) (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [1:0] err,
    input logic       mb_rd,
    input logic       mb_wr,
    input logic [2:0] mb_addr,
    input logic       rd_owner
);
    int   gap;
    logic rd_d;
    logic prev_owned;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap        <= 0;
            rd_d       <= 1'b0;
            prev_owned <= 1'b0;
        end else begin
            rd_d <= mb_rd;
            if (mb_rd)
                gap <= 0;
            else if (gap < (1 << 20))
                gap <= gap + 1;
            if (!busy)
                prev_owned <= 1'b0;
            else if (rd_d)
                prev_owned <= rd_owner;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mb_rd && !mb_wr)); // R1

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mb_rd && mb_wr)); // R5

    AST_WR_ASCEND: assert property (@(posedge clk) disable iff (rst)
        (mb_wr && mb_addr != 3'd7) |=> (mb_wr && mb_addr == $past(mb_addr) + 3'd1)); // R5

    AST_HDR_LAST: assert property (@(posedge clk) disable iff (rst)
        (mb_wr && mb_addr == 3'd7) |=> !mb_wr); // R6

    AST_POLL_GAP: assert property (@(posedge clk) disable iff (rst)
        (mb_rd && prev_owned) |-> (gap == WAIT_CYCLES + 1)); // R7

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R10

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(err) && $stable(done))); // R10
endmodule

bind mbx_setup_engine mbx_setup_checker #(.WAIT_CYCLES(WAIT_CYCLES)) u_mbx_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .mb_rd    (mb_rd),
    .mb_wr    (mb_wr),
    .mb_addr  (mb_addr),
    .rd_owner (mb_rdata[31])
);

// File: tb/mbx_setup_engine_bench.sv
module mbx_setup_engine_bench;
    localparam int MP = 5;
    localparam int WC = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        close_req = 1'b0;
    logic        reset_req = 1'b0;
    logic [63:0] evq_addr = '0, cmpq_addr = '0, rxq_addr = '0, txq_addr = '0;
    logic [31:0] irq_vec = '0;
    logic        mb_rd, mb_wr, busy, done;
    logic [2:0]  mb_addr;
    logic [31:0] mb_wdata;
    logic [31:0] mb_rdata = '0;
    logic [1:0]  err;

    always #4 clk = ~clk;

    mbx_setup_engine #(.MAX_POLLS(MP), .WAIT_CYCLES(WC), .REQ_VER(3'd0)) u_mbx_setup_engine (
        .clk(clk), .rst(rst), .start(start), .close_req(close_req), .reset_req(reset_req),
        .evq_addr(evq_addr), .cmpq_addr(cmpq_addr), .rxq_addr(rxq_addr), .txq_addr(txq_addr),
        .irq_vec(irq_vec), .mb_rd(mb_rd), .mb_wr(mb_wr), .mb_addr(mb_addr),
        .mb_wdata(mb_wdata), .mb_rdata(mb_rdata), .busy(busy), .done(done), .err(err)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int t_start = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // mailbox model
    logic [31:0] cap [8];
    int          seq [8];
    int          wr_cnt = 0;
    int          busy_left = 0;
    logic        posted = 1'b0;
    int          cfg_pre = 0, cfg_post = 0;
    logic [31:0] cfg_resp = '0;

    always @(posedge clk) begin
        if (start && !busy) begin
            busy_left <= cfg_pre;
            posted    <= 1'b0;
            wr_cnt    <= 0;
        end else begin
            if (mb_wr) begin
                cap[mb_addr] <= mb_wdata;
                if (wr_cnt < 8) seq[wr_cnt] <= int'(mb_addr);
                wr_cnt <= wr_cnt + 1;
                if (mb_addr == 3'd7) begin
                    posted    <= 1'b1;
                    busy_left <= cfg_post;
                end
            end
            if (mb_rd) begin
                if (busy_left > 0) begin
                    mb_rdata  <= 32'h8000_0000;
                    busy_left <= busy_left - 1;
                end else begin
                    mb_rdata <= posted ? cfg_resp : 32'h0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=0x%0h exp=0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [255:0] build(input bit cl, input logic [63:0] a0, input logic [63:0] a1,
                                           input logic [63:0] a2, input logic [63:0] a3,
                                           input logic [31:0] v, input bit rv);
        logic [7:0]  b [32];
        logic [63:0] a [4];
        logic [51:0] pfn;
        logic [15:0] hi;
        logic [255:0] f;
        a[0] = a0; a[1] = a1; a[2] = a2; a[3] = a3;
        hi = '0;
        for (int q = 0; q < 4; q++) begin
            pfn = 52'(a[q] >> 12);
            for (int j = 0; j < 6; j++) b[6*q+j] = pfn[8*j +: 8];
            hi = hi | (16'(pfn[51:48]) << (4*q));
        end
        b[24] = hi[7:0];
        b[25] = hi[15:8];
        b[26] = v[7:0];
        b[27] = v[15:8];
        b[28] = cl ? 8'h02 : 8'h01;
        b[29] = 8'h00;
        b[30] = 8'h00;
        b[31] = {7'b0, rv};
        for (int i = 0; i < 32; i++) f[8*i +: 8] = b[i];
        return f;
    endfunction

    typedef struct {
        string        tag;
        logic [1:0]   err;
        int           nwr;
        int           lat;
        logic [255:0] frm;
    } exp_t;

    exp_t exp_q[$];

    // monitor / scoreboard
    initial begin
        forever begin
            exp_t e;
            @(posedge done);
            @(negedge clk);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10", "unexpected done", 64'(err), 64'hx);
                continue;
            end
            e = exp_q.pop_front();
            chk(err == e.err, e.tag, "err", 64'(err), 64'(e.err));
            chk(wr_cnt == e.nwr, e.tag, "write count", 64'(wr_cnt), 64'(e.nwr));
            if (e.lat >= 0)
                chk((cyc - t_start) == e.lat, "R7", "latency", 64'(cyc - t_start), 64'(e.lat));
            if (e.nwr == 8) begin
                for (int k = 0; k < 8; k++) begin
                    chk(cap[k] == e.frm[32*k +: 32], (k < 7) ? "R4" : "R5", "dword",
                        64'(cap[k]), 64'(e.frm[32*k +: 32]));
                    chk(seq[k] == k, "R5", "write order", 64'(seq[k]), 64'(k));
                end
            end else if (e.nwr == 1) begin
                chk(cap[7] == e.frm[255:224], "R6", "header", 64'(cap[7]), 64'(e.frm[255:224]));
                chk(seq[0] == 7, "R6", "header index", 64'(seq[0]), 64'd7);
            end
        end
    end

    task automatic run(input string tag, input bit cl,
                       input logic [63:0] a0, input logic [63:0] a1,
                       input logic [63:0] a2, input logic [63:0] a3,
                       input logic [31:0] v, input bit rv, input int p, input int q,
                       input logic [31:0] resp, input logic [1:0] e, input int nwr,
                       input int lat, input bit poke);
        exp_t it;
        it.tag = tag; it.err = e; it.nwr = nwr; it.lat = lat;
        it.frm = build(cl, a0, a1, a2, a3, v, rv);
        cfg_pre = p; cfg_post = q; cfg_resp = resp;
        @(negedge clk);
        close_req = cl; evq_addr = a0; cmpq_addr = a1; rxq_addr = a2; txq_addr = a3;
        irq_vec = v; reset_req = rv; start = 1'b1;
        exp_q.push_back(it);
        @(negedge clk);
        start = 1'b0;
        t_start = cyc;
        if (poke) begin
            @(negedge clk);
            start = 1'b1; close_req = !cl; irq_vec = 32'h1234_0000;
            @(negedge clk);
            start = 1'b0;
        end
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    localparam logic [63:0] A0 = 64'h0000_0012_3456_7000;
    localparam logic [63:0] A1 = 64'hF000_0000_0000_1000;
    localparam logic [63:0] A2 = 64'h0ABC_DEF0_1234_5000;
    localparam logic [63:0] A3 = 64'h8000_0000_0000_0000;

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired act=0x0 exp=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy", 64'(busy), 64'd0);
        chk(done == 1'b0, "R1", "done", 64'(done), 64'd0);
        chk(err == 2'd0, "R1", "err", 64'(err), 64'd0);
        chk(!mb_rd && !mb_wr, "R1", "strobes", 64'({mb_rd, mb_wr}), 64'd0);

        // R4 R5 R7: open request with busy polls on both sides
        run("R4", 1'b0, A0, A1, A2, A3, 32'h0000_BEEF, 1'b0, 2, 1, 32'h0000_0081, 2'd0, 8, 27, 1'b0);
        // R6: close with reset flag, no busy polls
        run("R6", 1'b1, A0, A1, A2, A3, 32'h0, 1'b1, 0, 0, 32'h0000_0082, 2'd0, 1, 5, 1'b0);
        // R2: timeout before request, then boundary at MP-1 busy reads
        run("R2", 1'b0, A0, A1, A2, A3, 32'h5, 1'b0, MP, 0, 32'h81, 2'd1, 0, (MP-1)*(WC+2)+2, 1'b0);
        run("R2", 1'b0, A3, A2, A1, A0, 32'hFFFF, 1'b1, MP-1, 0, 32'h81, 2'd0, 8, (MP-1)*(WC+2)+12, 1'b0);
        // R3: argument checks
        run("R3", 1'b0, 64'h0000_0000_0000_0800, A1, A2, A3, 32'h1, 1'b0, 1, 0, 32'h81, 2'd2, 0, (WC+2)+2, 1'b0);
        run("R3", 1'b0, A0, A1, A2, A3, 32'h0001_0000, 1'b0, 0, 0, 32'h81, 2'd2, 0, 2, 1'b0);
        run("R3", 1'b1, 64'h123, A1, A2, A3, 32'hFFFF_FFFF, 1'b0, 0, 0, 32'h82, 2'd0, 1, 5, 1'b0);
        // R9: reply validation
        run("R9", 1'b0, A0, A1, A2, A3, 32'h7, 1'b0, 0, 0, 32'h0000_0082, 2'd3, 8, 12, 1'b0);
        run("R9", 1'b0, A0, A1, A2, A3, 32'h7, 1'b0, 0, 0, 32'h0000_0089, 2'd3, 8, 12, 1'b0);
        run("R9", 1'b0, A0, A1, A2, A3, 32'h7, 1'b0, 0, 0, 32'h0000_0001, 2'd3, 8, 12, 1'b0);
        run("R9", 1'b0, A0, A1, A2, A3, 32'h7, 1'b0, 0, 0, 32'h0000_0181, 2'd3, 8, 12, 1'b0);
        // R8: all-ones readback with and without reset flag, post timeout
        run("R8", 1'b0, A0, A1, A2, A3, 32'h22, 1'b1, 0, 2, 32'hFFFF_FFFF, 2'd0, 8, 2*(WC+2)+12, 1'b0);
        run("R8", 1'b1, A0, A1, A2, A3, 32'h0, 1'b0, 0, 0, 32'hFFFF_FFFF, 2'd1, 1, 3+(MP-1)*(WC+2)+2, 1'b0);
        run("R8", 1'b0, A0, A1, A2, A3, 32'h3, 1'b0, 0, MP, 32'h81, 2'd1, 8, 10+(MP-1)*(WC+2)+2, 1'b0);
        // R10: start while busy ignored, result held afterwards
        run("R10", 1'b0, A2, A0, A3, A1, 32'h0000_0042, 1'b0, 2, 0, 32'h0000_0089, 2'd3, 8, 2*(WC+2)+12, 1'b1);
        repeat (6) @(negedge clk);
        chk(done == 1'b1, "R10", "done held", 64'(done), 64'd1);
        chk(err == 2'd3, "R10", "err held", 64'(err), 64'd3);
        chk(!busy, "R10", "idle after", 64'(busy), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule